// File: doc/BRIEF.md
# Configurable GPIO Ports with Level Interrupts

This block provides four 8-bit general-purpose ports. Ports 0 and 1 are bidirectional. Ports 2 and 3 can only be read. Software sets a 2-bit mode for every pin on its own. The mode makes the pin a plain input, a driven output, an input that interrupts while high, or an input that interrupts while low. Every input level passes through a two-flop synchroniser. The synchronised value is the one software reads and the one the interrupt logic watches.

Each port drives one interrupt line toward the host interrupt controller. The host maps port 0 to interrupt number 21 and the following ports to 20, 19 and 18. A line is the OR of every pin of that port that is in an interrupt mode and is currently at its active level. Nothing is latched, so the line drops as soon as the level goes away. Software reaches the block through a single-cycle write strobe and a combinational read port. One address space serves both.

Top module: `gpio_level_irq`

## Requirements
- R1: While reset is held, every register reads zero. Every pin is a plain input, `pin_oe` is zero and `irq` is zero.
- R2: Register address is `{port[1:0], sel[1:0]}`. sel 1 is the mode register. Bits [2i+1:2i] hold pin i's code: 00 input, 01 output, 10 interrupt while high, 11 interrupt while low. The register reads back exactly as written.
- R3: sel 0 is the data-out register, bits [7:0]. On ports 0 and 1 it reads back as written and drives `pin_out`. `pin_oe` is set for exactly the pins in mode 01.
- R4: On ports 2 and 3, mode 01 is ignored and the pin acts as a plain input. The direction register (sel 3, read-only, bit i set when pin i drives) reads zero there. Writes to their data-out register are ignored, and it reads zero.
- R5: sel 2 is read-only and returns the port's pin levels after a two-flop synchroniser. A change on `pin_in` appears after two rising clock edges. Writes to sel 2 have no effect.
- R6: A pin in mode 10 holds its port's `irq` bit high while its synchronised level is 1.
- R7: A pin in mode 11 holds its port's `irq` bit high while its synchronised level is 0.
- R8: A port's `irq` bit is the OR over its interrupting pins. It is not latched, and it falls two edges after the last active level goes away. Pins in mode 00 or 01 never contribute.
- R9: Pins in either interrupt mode have their output driver disabled, and their levels stay readable through sel 2.
- R10: `irq[k]` belongs to port k only (host interrupt number 21-k). A pin of one port never raises another port's bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address {port, sel} |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| pin_in | input | 32 | Pin levels, port k on bits [8k+7:8k] |
| pin_out | output | 16 | Output values for ports 0 and 1 |
| pin_oe | output | 16 | Output enables for ports 0 and 1 |
| irq | output | 4 | Level interrupt per port |

## Verification
A mode write and a pin-level change can take effect in the same cycle. The bench provokes this by switching a pin to active-low mode on the very clock edge at which its pin falls. It then checks that `irq` stays low for one more cycle, while the old synchronised level is still seen, and rises exactly on the second edge. It also checks that the line falls two edges after the pin returns high, with no latched remainder. A sweep over every port, pin, mode and level judges the interrupt, direction, readback and level values against arithmetic expectations.

// File: rtl/gpio_level_irq.sv
module gpio_level_irq #(
  parameter int NPORTS = 4,
  parameter int WIDTH  = 8,
  parameter int NBIDIR = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_we,
  input  logic [$clog2(NPORTS)+1:0]     reg_addr,
  input  logic [2*WIDTH-1:0]            reg_wdata,
  output logic [2*WIDTH-1:0]            reg_rdata,
  input  logic [NPORTS*WIDTH-1:0]       pin_in,
  output logic [NBIDIR*WIDTH-1:0]       pin_out,
  output logic [NBIDIR*WIDTH-1:0]       pin_oe,
  output logic [NPORTS-1:0]             irq
);
  localparam int PW = $clog2(NPORTS);
  localparam int MW = 2*WIDTH;
  localparam logic [1:0] M_OUT = 2'b01;
  localparam logic [1:0] M_HI  = 2'b10;
  localparam logic [1:0] M_LO  = 2'b11;
  localparam logic [1:0] S_DOUT = 2'd0;
  localparam logic [1:0] S_MODE = 2'd1;
  localparam logic [1:0] S_LVL  = 2'd2;
  localparam logic [1:0] S_DIR  = 2'd3;

  logic [PW-1:0] a_port;
  logic [1:0]    a_sel;
  assign a_port = reg_addr[PW+1:2];
  assign a_sel  = reg_addr[1:0];

  logic [NPORTS*WIDTH-1:0] s1_q, s2_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_in;
      s2_q <= s1_q;
    end

  logic [NPORTS*WIDTH-1:0] dout_w, dir_w;
  logic [NPORTS*MW-1:0]    mode_w;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    logic [MW-1:0]    mode_r;
    logic [WIDTH-1:0] hit_w;
    logic             wr_hit;
    assign wr_hit = reg_we && (a_port == PW'(p));

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) mode_r <= '0;
      else if (wr_hit && a_sel == S_MODE) mode_r <= reg_wdata;
    assign mode_w[p*MW +: MW] = mode_r;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic [1:0] m;
      logic       lv;
      assign m  = mode_r[2*i +: 2];
      assign lv = s2_q[p*WIDTH + i];
      assign dir_w[p*WIDTH + i] = (p < NBIDIR) && (m == M_OUT);
      assign hit_w[i] = ((m == M_HI) && lv) || ((m == M_LO) && !lv);
    end
    assign irq[p] = |hit_w;

    if (p < NBIDIR) begin : g_bidir
      logic [WIDTH-1:0] dout_r;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dout_r <= '0;
        else if (wr_hit && a_sel == S_DOUT) dout_r <= reg_wdata[WIDTH-1:0];
      assign dout_w[p*WIDTH +: WIDTH]  = dout_r;
      assign pin_out[p*WIDTH +: WIDTH] = dout_r;
      assign pin_oe[p*WIDTH +: WIDTH]  = dir_w[p*WIDTH +: WIDTH];

      p_drive_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_we) |-> ($stable(pin_out[p*WIDTH +: WIDTH]) && $stable(pin_oe[p*WIDTH +: WIDTH])));
    end else begin : g_ronly
      assign dout_w[p*WIDTH +: WIDTH] = '0;

      p_ronly_no_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_port == PW'(p) && (a_sel == S_DIR || a_sel == S_DOUT)) |-> (reg_rdata == '0));
    end

    p_irq_level_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(reg_we) && $stable(s2_q[p*WIDTH +: WIDTH])) |-> $stable(irq[p]));
  end

  always_comb begin
    reg_rdata = '0;
    for (int p = 0; p < NPORTS; p++)
      if (a_port == PW'(p))
        case (a_sel)
          S_DOUT:  reg_rdata[WIDTH-1:0] = dout_w[p*WIDTH +: WIDTH];
          S_MODE:  reg_rdata            = mode_w[p*MW +: MW];
          S_LVL:   reg_rdata[WIDTH-1:0] = s2_q[p*WIDTH +: WIDTH];
          default: reg_rdata[WIDTH-1:0] = dir_w[p*WIDTH +: WIDTH];
        endcase
  end

  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm_q <= '0;
    else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;

  p_sync_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q == 2'd2) |-> (s2_q == $past(pin_in, 2)));

  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (irq == '0 && pin_oe == '0));
endmodule

// File: tb/test_gpio_level_irq.sv
module test_gpio_level_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0, we = 0;
  logic [3:0]  addr = 0;
  logic [15:0] wdata = 0;
  logic [31:0] pin_in = 0;
  wire  [15:0] rdata, pin_out, pin_oe;
  wire  [3:0]  irq;
  int total = 0, bad = 0;
  bit done = 0;

  gpio_level_irq i_gpio_level_irq (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
    .reg_rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=%h exp=%h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 irq", irq, 0);
    chk("R1 oe", pin_oe, 0);
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), r);
      chk("R1 reg", r, 0);
    end
    rst_n = 1;

    for (int p = 0; p < 2; p++) begin
      wr({2'(p), 2'd1}, 16'h5555);
      for (int v = 0; v < 256; v++) begin
        wr({2'(p), 2'd0}, 16'(v));
        rd({2'(p), 2'd0}, r);
        chk("R3 dout read", r, v);
        chk("R3 pin_out", pin_out[p*8 +: 8], v);
      end
      chk("R3 oe all", pin_oe[p*8 +: 8], 8'hFF);
      wr({2'(p), 2'd1}, 16'h0000);
    end
    for (int p = 2; p < 4; p++) begin
      wr({2'(p), 2'd0}, 16'h00FF);
      rd({2'(p), 2'd0}, r);
      chk("R4 ronly dout ignored", r, 0);
    end

    wr(4'd0, 16'h00A5);
    wr(4'd4, 16'h003C);
    for (int p = 0; p < 4; p++) begin
      for (int i = 0; i < 8; i++)
        for (int m = 0; m < 4; m++)
          for (int l = 0; l < 2; l++) begin
            bit drv, act;
            string tag;
            pin_in = 32'(l) << (p*8 + i);
            wr({2'(p), 2'd1}, 16'(m) << (2*i));
            settle();
            drv = (m == 1) && (p < 2);
            act = ((m == 2) && l == 1) || ((m == 3) && l == 0);
            tag = (m == 2) ? "R6 irq" : (m == 3) ? "R7 irq" : "R8 no irq";
            chk(tag, irq, 4'(act) << p);
            chk("R10 other ports", irq & ~(4'd1 << p), 0);
            rd({2'(p), 2'd1}, r);
            chk("R2 mode read", r, 16'(m) << (2*i));
            rd({2'(p), 2'd2}, r);
            chk(m >= 2 ? "R9 level read" : "R5 level read", r, 16'(l) << i);
            rd({2'(p), 2'd3}, r);
            chk(p >= 2 ? "R4 dir read" : "R3 dir read", r, 16'(drv) << i);
            chk(m >= 2 ? "R9 oe off" : "R3 oe", pin_oe, 16'(drv) << (p*8 + i));
            chk("R3 pin_out held", pin_out, 16'h3CA5);
          end
      wr({2'(p), 2'd1}, 16'h0000);
    end

    pin_in = 0;
    settle();
    pin_in[24] = 1;
    @(negedge clk); #1;
    rd(4'd14, r);
    chk("R5 one edge", r, 0);
    @(negedge clk); #1;
    rd(4'd14, r);
    chk("R5 two edges", r, 1);
    wr(4'd14, 16'h0000);
    #1;
    rd(4'd14, r);
    chk("R5 write ignored", r, 1);
    pin_in = 0;

    wr(4'd5, 16'h0802);
    pin_in[8] = 1; pin_in[13] = 1;
    settle();
    chk("R8 or two", irq, 4'b0010);
    pin_in[8] = 0;
    settle();
    chk("R8 or one", irq, 4'b0010);
    pin_in[13] = 0;
    settle();
    chk("R8 cleared", irq, 0);
    pin_in[10] = 1;
    settle();
    chk("R8 input pin no irq", irq, 0);
    pin_in = 0;
    wr(4'd5, 16'h0000);

    pin_in[3] = 1;
    settle();
    @(negedge clk); we = 1; addr = 4'd1; wdata = 16'h00C0; pin_in[3] = 0;
    @(negedge clk); we = 0; #1;
    chk("R7 coincident edge1", irq, 0);
    @(negedge clk); #1;
    chk("R7 coincident edge2", irq, 4'b0001);
    pin_in[3] = 1;
    @(negedge clk); #1;
    chk("R8 release edge1", irq, 4'b0001);
    @(negedge clk); #1;
    chk("R8 release edge2", irq, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule